// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block is a system monitor for a small 8-bit controller. It counts instruction-cycle ticks (the oscillator divided by 12, delivered as a one-cycle clock enable) through a power-of-two prescaler into a wide timer. If the timer wraps while the watchdog is enabled, the block raises a one-cycle reset request for the rest of the chip. Software keeps the system alive by setting the self-clearing clear bit before the timer wraps. That bit restarts both the prescaler and the timer at the next instruction cycle.

One 8-bit control register holds the whole configuration. It has an enable bit, the clear bit, a bit that keeps counting alive while the core is idle, and a 3-bit ratio select. With default parameters the timeout is 2^14 × 2^(sel+1) ticks, or 2^14 × ratio × 12 oscillator periods. Any reset disables the watchdog and empties both counters.

Top module: `pwdog_top`

## Requirements
- R1: After `rst` is high at a clock edge, `rd_data` reads 0x00 and `rst_req` is 0. The timer and prescaler are zero, so after a later enable with no clear, the first request comes after exactly one full period.
- R2: Control register bit positions are: bit 7 enable, bit 6 clear, bit 5 idle-run, bits 2:0 ratio select. Bits 4:3 always read 0. A write takes effect at the clock edge that samples `wr_en`, and `rd_data` shows the register at all times.
- R3: While enabled and not frozen, each cycle with `tick` high, other than a cycle that performs a clear, is one counted tick. `rst_req` is high in the cycle after the edge that samples counted tick number 2^CNT_W × ratio.
- R4: Ratio select value n gives a ratio of 2^(n+1), from 2 (n=0) up to 256 (n=7).
- R5: `rst_req` is high for exactly one cycle. Counting resumes from zero, so the next request follows after another full period of counted ticks.
- R6: Writing 1 to bit 6 sets it. At the first edge after the write where `tick` is high, the prescaler, the timer and bit 6 return to zero, and that tick is not counted. Writing 0 to bit 6 while it is set does not cancel the pending clear.
- R7: When `idle` is high and idle-run is 0, counting is frozen and the count is held. When idle-run is 1, counting continues while `idle` is high.
- R8: When enable is 0, the count is held (not cleared) and `rst_req` stays 0. Re-enabling resumes from the held count.
- R9: Cycles with `tick` low neither count nor perform a pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle clock enable (oscillator / 12) |
| idle | input | 1 | High while the core is in idle mode |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| rst_req | output | 1 | One-cycle internal reset request on timeout |

## Verification
The timeout is measured to the exact cycle for ratio selects 0, 1, 2, 3 and 7. This separates a correct ratio decode from one that is off by one power of two, and separates a counted clear tick from an uncounted one. A second back-to-back period shows whether the timer restarts from zero. The count is then interrupted in four different ways: an idle stretch with idle-run clear, a disable phase, a fresh clear mid-count, and a reset mid-count. The remaining time in each case shows whether the count was held, kept or emptied. A sparse tick pattern (one tick in three cycles) shows that only ticks advance the count, and that an idle stretch with idle-run set does not slow it.

// File: rtl/pwdog_pkg.sv
package pwdog_pkg;

    localparam int CTRL_W  = 8;
    localparam int PSEL_W  = 3;
    // prescaler needs enough bits for the largest ratio 2^(2^PSEL_W)
    localparam int PSC_W   = 1 << PSEL_W;

    // control register image, most significant field first
    typedef struct packed {
        logic              en;
        logic              clr;
        logic              irun;
        logic [1:0]        rsvd;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    // per-cycle advance command handed from the gate to the counters
    typedef struct packed {
        logic step;
        logic sclr;
    } adv_t;

    // terminal prescaler value for a given select: ratio 2^(sel+1)
    function automatic logic [PSC_W-1:0] psc_last(input logic [PSEL_W-1:0] sel);
        psc_last = PSC_W'((32'd2 << sel) - 32'd1);
    endfunction

    // counting is allowed when enabled and not frozen by idle
    function automatic logic run_gate(input logic en, input logic idle, input logic irun);
        run_gate = en & (~idle | irun);
    endfunction

endpackage

// File: rtl/pwdog_ctrl.sv
module pwdog_ctrl
    import pwdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             cfg
);

    ctrl_t w;
    logic  en_q, clr_q, irun_q;
    logic [PSEL_W-1:0] psel_q;
    logic  unused_rsvd_bits;

    assign w = ctrl_t'(wr_data);
    assign unused_rsvd_bits = ^w.rsvd;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            irun_q <= 1'b0;
            psel_q <= '0;
        end else if (wr_en) begin
            en_q   <= w.en;
            irun_q <= w.irun;
            psel_q <= w.psel;
        end
    end

    // clear request: set by writing 1, consumed by the next tick;
    // writing 0 never cancels it
    always_ff @(posedge clk) begin
        if (rst)
            clr_q <= 1'b0;
        else if (wr_en && w.clr)
            clr_q <= 1'b1;
        else if (tick)
            clr_q <= 1'b0;
    end

    always_comb begin
        cfg      = '0;
        cfg.en   = en_q;
        cfg.clr  = clr_q;
        cfg.irun = irun_q;
        cfg.psel = psel_q;
    end

    // R6: a pending clear disappears after a tick with no new write
    p_clr_autoclear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_q && tick && !wr_en) |=> !clr_q);

    // R6: writing 0 to the clear bit keeps a pending clear
    p_clr_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_q && !tick && wr_en) |=> clr_q);

endmodule

// File: rtl/pwdog_prescaler.sv
module pwdog_prescaler
    import pwdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  adv_t              adv,
    input  logic [PSEL_W-1:0] psel,
    output logic              carry
);

    logic [PSC_W-1:0] psc;
    logic [PSC_W-1:0] last;
    logic             at_end;

    assign last   = psc_last(psel);
    // >= keeps the wrap sane if the select shrinks mid-count
    assign at_end = (psc >= last);
    assign carry  = adv.step & at_end;

    always_ff @(posedge clk) begin
        if (rst || adv.sclr)
            psc <= '0;
        else if (adv.step)
            psc <= at_end ? '0 : psc + 1'b1;
    end

    // R6: a clear leaves the prescaler at zero
    p_psc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        adv.sclr |=> (psc == '0));

    // R7/R8: without a step the prescaler holds its value
    p_psc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!adv.step && !adv.sclr) |=> $stable(psc));

endmodule

// File: rtl/pwdog_timer.sv
module pwdog_timer
    import pwdog_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic sclr,
    output logic ovf
);

    logic [CNT_W-1:0] cnt;

    assign ovf = inc & (&cnt);

    always_ff @(posedge clk) begin
        if (rst || sclr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // R3: each prescaler carry advances the timer by one, wrapping
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !sclr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6: a clear empties the timer
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
        sclr |=> (cnt == '0));

    // R8: no carry, no change
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!inc && !sclr) |=> $stable(cnt));

endmodule

// File: rtl/pwdog_top.sv
module pwdog_top
    import pwdog_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              idle,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              rst_req
);

    ctrl_t cfg;
    adv_t  adv;
    logic  psc_carry;
    logic  tmr_ovf;

    pwdog_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    // a tick either performs a pending clear or counts, never both
    always_comb begin
        adv.sclr = tick & cfg.clr;
        adv.step = tick & ~cfg.clr & run_gate(cfg.en, idle, cfg.irun);
    end

    pwdog_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .psel  (cfg.psel),
        .carry (psc_carry)
    );

    pwdog_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .inc  (psc_carry),
        .sclr (adv.sclr),
        .ovf  (tmr_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rst_req <= 1'b0;
        else
            rst_req <= tmr_ovf;
    end

    assign rd_data = cfg;

    // R5: the request never lasts two cycles
    p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8: a request only follows a cycle in which the watchdog was enabled
    p_req_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(cfg.en));

    // R2: reserved bits never read as 1
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[4:3] == 2'b00);

endmodule

// File: tb/pwdog_top_bench.sv
module pwdog_top_bench;

    localparam int CW     = 8;
    localparam int BASE   = 1 << CW;
    localparam int WD_MAX = 180000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       idle = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_req;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwdog_top #(.CNT_W(CW)) u_pwdog_top (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .idle    (idle),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // counts negedges until rst_req is seen (or maxc)
    task automatic wait_pulse(input int maxc, output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!rst_req && c < maxc);
    endtask

    // runs n cycles, returns how many had rst_req high
    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
    endtask

    task automatic t_reset_state;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R1 rst_req after reset", rst_req, 0);
    endtask

    task automatic t_layout;
        wr(8'hFF);
        chk("R2 readback with clear pending", rd_data, 8'hE7);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R2 readback after clear consumed", rd_data, 8'hA7);
        wr(8'h00);
        chk("R2 readback disabled", rd_data, 8'h00);
    endtask

    task automatic t_ratio(input int sel);
        int c;
        int period;
        period = BASE * (2 << sel);
        wr(8'hC0 | 8'(sel));
        tick = 1'b1;
        wait_pulse(period + 8, c);
        tick = 1'b0;
        chk($sformatf("R4 R3 timeout cycles sel=%0d", sel), c, period + 1);
    endtask

    task automatic t_period_repeat;
        int c;
        wr(8'hC0);
        tick = 1'b1;
        wait_pulse(2 * BASE + 8, c);
        chk("R3 first timeout", c, 2 * BASE + 1);
        @(negedge clk);
        chk("R5 request lasts one cycle", rst_req, 0);
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        chk("R5 next timeout from zero", c, 2 * BASE - 1);
    endtask

    task automatic t_clear;
        int c;
        int seen;
        wr(8'hC0);
        tick = 1'b1;
        quiet(300, seen);
        tick = 1'b0;
        chk("R6 no request before clear", seen, 0);
        wr(8'hC0);
        wr(8'h80);
        chk("R6 writing 0 keeps pending clear", rd_data, 8'hC0);
        chk("R9 clear waits for tick", rd_data[6], 1);
        tick = 1'b1;
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        chk("R6 full period after mid-count clear", c, 2 * BASE + 1);
    endtask

    task automatic t_idle;
        int c;
        int seen;
        wr(8'hC0);
        tick = 1'b1;
        quiet(100, seen);
        idle = 1'b1;
        quiet(50, seen);
        idle = 1'b0;
        chk("R7 frozen in idle", seen, 0);
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        chk("R7 idle cycles not counted", c, 2 * BASE + 1 - 100);
        wr(8'hE0);
        chk("R2 idle-run readback", rd_data, 8'hE0);
        idle = 1'b1;
        tick = 1'b1;
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        idle = 1'b0;
        chk("R7 idle-run keeps counting", c, 2 * BASE + 1);
    endtask

    task automatic t_disable;
        int c;
        int seen;
        wr(8'hC0);
        tick = 1'b1;
        quiet(200, seen);
        tick = 1'b0;
        wr(8'h00);
        tick = 1'b1;
        quiet(1000, seen);
        tick = 1'b0;
        chk("R8 no request while disabled", seen, 0);
        wr(8'h80);
        tick = 1'b1;
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        chk("R8 count held across disable", c, 2 * BASE + 1 - 200);
    endtask

    task automatic t_sparse_tick;
        int seen;
        seen = 0;
        wr(8'hC0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < 2 * BASE - 1; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (rst_req) seen++;
            tick = 1'b0;
            @(negedge clk);
            if (rst_req) seen++;
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R9 gaps not counted", seen, 0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R9 request on last counted tick", rst_req, 1);
    endtask

    task automatic t_mid_reset;
        int c;
        int seen;
        wr(8'hC3);
        tick = 1'b1;
        quiet(500, seen);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        tick = 1'b0;
        chk("R1 rd_data after mid-count reset", rd_data, 8'h00);
        wr(8'h80);
        tick = 1'b1;
        wait_pulse(2 * BASE + 8, c);
        tick = 1'b0;
        chk("R1 counters emptied by reset", c, 2 * BASE);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_MAX);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_layout();
        t_ratio(0);
        t_ratio(1);
        t_ratio(2);
        t_ratio(3);
        t_ratio(7);
        t_period_repeat();
        t_clear();
        t_idle();
        t_disable();
        t_sparse_tick();
        t_mid_reset();
        finish_run();
    end

endmodule